// File: doc/BRIEF.md
# Load-Instruction Machine-Cycle Sequencer

This block is the execution engine for the byte-load subset of an 8-bit accumulator processor. It fetches instruction bytes over a byte-wide memory bus and runs each instruction as a sequence of machine cycles. Each cycle lasts the exact number of clock states its kind calls for. An opcode fetch takes four states and drives the opcode-fetch strobe. An ordinary read or write takes three states. An extended cycle takes five states and forms the indexed effective address. The sequencer holds the byte registers A, B, C, D, E, H and L. It also holds the two 16-bit index bases, which are preset by parameter because no instruction in this subset writes them.

Supported transfers move bytes between registers and memory. The address comes from a register pair, from a direct 16-bit address in the instruction stream, or from an index base plus a signed displacement. An immediate byte can also be stored through HL or through an index. Every other opcode runs as a single fetch cycle that changes nothing. The memory is expected to return read data combinationally within the cycle. The sequencer samples the data on the clock edge that ends a read cycle. A write takes effect on the edge that ends the cycle's third state, which is the only state in which the write strobe is high.

Top module: `ldseq_top`

## Requirements
- R1: After synchronous reset the sequencer starts an opcode fetch at address PC_INIT in state 1, with bus_m1 and bus_rd high and bus_wr low. All byte registers read as zero.
- R2: An opcode fetch lasts 4 states with bus_m1 and bus_rd high throughout. A read cycle lasts 3 states with bus_rd high. A write cycle lasts 3 states with bus_rd low, bus_wr high only in state 3, and address and data held for the whole cycle. t_state numbers the states of the current cycle from 1.
- R3: Opcode 0x02 writes A to address {B,C}, and 0x12 writes A to {D,E}. Each takes 2 cycles and 7 states.
- R4: Opcode 0x32 writes A to the 16-bit address taken from the next two bytes, low byte first. It takes 4 cycles and 13 states.
- R5: Opcode 0x36 writes the next byte to address {H,L} in 3 cycles and 10 states.
- R6: Opcode 01rrr110 with rrr not 110 loads a register from {H,L} in 2 cycles and 7 states. The codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111.
- R7: Opcodes 0x0A and 0x1A load A from {B,C} and {D,E} in 7 states. Opcode 0x3A loads A from a direct address, low byte first, in 4 cycles and 13 states.
- R8: A prefix byte 11x11101 selects the first index base when bit 5 is 0 and the second when bit 5 is 1. When it is followed by 01rrr110 and a displacement d, the register is loaded from base + sign-extended d modulo 2^16. This takes 5 cycles (4,4,3,5,3) and 19 states, and the 5-state cycle drives no strobe.
- R9: Prefix, 0x36, d, n writes n to base + sign-extended d in 5 cycles (4,4,3,5,3) and 19 states. The 5-state cycle reads n at the program counter.
- R10: Any other opcode, including 0x76, is one 4-state fetch that changes no register and performs no write. A prefix followed by any byte other than the two indexed forms is consumed as a two-fetch, 8-state pair that has no effect.
- R11: The program counter advances by one for every prefix, opcode, displacement, immediate and address byte, and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | output | AW | Memory address |
| bus_rdata | input | 8 | Read data, valid in the cycle the address is driven |
| bus_wdata | output | 8 | Write data |
| bus_m1 | output | 1 | High during opcode fetch cycles |
| bus_rd | output | 1 | High during fetch and read cycles |
| bus_wr | output | 1 | High in the third state of a write cycle |
| t_state | output | 3 | State number within the current machine cycle, from 1 |

## Verification
The bench builds the block with PC_INIT at 0xFFF4, so the instruction stream crosses the 16-bit wrap of the program counter within the first few instructions. The first index base is set to 0x0040, so negative displacements wrap below zero. The second is set to 0xFFC0, so positive displacements wrap above 0xFFFF. With these values the wrap cases of address generation and of the program counter come up in both the directed opening and the random stream, without running tens of thousands of cycles.

// File: rtl/ldseq_pkg.sv
// Shared types and constants for the load sequencer.
// Assumes byte-wide data and a two-byte address for pair and direct modes.
package ldseq_pkg;

    localparam int BW = 8;

    // Opcode values the decoder recognises
    localparam logic [BW-1:0] OPC_ST_BC  = 8'h02;
    localparam logic [BW-1:0] OPC_ST_DE  = 8'h12;
    localparam logic [BW-1:0] OPC_ST_NN  = 8'h32;
    localparam logic [BW-1:0] OPC_ST_HLN = 8'h36;
    localparam logic [BW-1:0] OPC_LD_BC  = 8'h0A;
    localparam logic [BW-1:0] OPC_LD_DE  = 8'h1A;
    localparam logic [BW-1:0] OPC_LD_NN  = 8'h3A;

    // Register file slots (code 111 for A is folded onto slot 6)
    localparam logic [2:0] SLOT_B = 3'd0;
    localparam logic [2:0] SLOT_C = 3'd1;
    localparam logic [2:0] SLOT_D = 3'd2;
    localparam logic [2:0] SLOT_E = 3'd3;
    localparam logic [2:0] SLOT_H = 3'd4;
    localparam logic [2:0] SLOT_L = 3'd5;
    localparam logic [2:0] SLOT_A = 3'd6;

    typedef enum logic [3:0] {
        P_OP, P_DISP, P_CALC, P_XIMM, P_ALO, P_AHI, P_IMM, P_RD, P_WR
    } phase_e;

    typedef enum logic [3:0] {
        C_NOP, C_PFX, C_ST_BC, C_ST_DE, C_ST_NN, C_ST_HLN,
        C_LD_BC, C_LD_DE, C_LD_NN, C_LD_RHL, C_X_STN, C_X_LDR
    } cls_e;

    // Map a 3-bit register code onto a register file slot
    function automatic logic [2:0] slot_of(input logic [2:0] code);
        return (code == 3'd7) ? SLOT_A : code;
    endfunction

    // Number of clock states in the machine cycle of a phase
    function automatic logic [2:0] phase_len(input phase_e p);
        case (p)
            P_OP:           return 3'd4;
            P_CALC, P_XIMM: return 3'd5;
            default:        return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/ldseq_decode.sv
// Opcode classifier. Purely combinational.
// Assumes: pfx is high when the byte follows an index prefix.
module ldseq_decode
    import ldseq_pkg::*;
(
    input  logic [BW-1:0] op,
    input  logic          pfx,
    output cls_e          cls
);

    logic is_pfx_byte;
    logic is_mem_ld;

    assign is_pfx_byte = (op[7:6] == 2'b11) && (op[4:0] == 5'b11101);
    assign is_mem_ld   = (op[7:6] == 2'b01) && (op[2:0] == 3'b110) && (op[5:3] != 3'b110);

    // Classify the opcode byte; any unknown pattern becomes a no-op
    always_comb begin
        cls = C_NOP;
        if (!pfx) begin
            if (is_pfx_byte)            cls = C_PFX;
            else if (op == OPC_ST_BC)   cls = C_ST_BC;
            else if (op == OPC_ST_DE)   cls = C_ST_DE;
            else if (op == OPC_ST_NN)   cls = C_ST_NN;
            else if (op == OPC_ST_HLN)  cls = C_ST_HLN;
            else if (op == OPC_LD_BC)   cls = C_LD_BC;
            else if (op == OPC_LD_DE)   cls = C_LD_DE;
            else if (op == OPC_LD_NN)   cls = C_LD_NN;
            else if (is_mem_ld)         cls = C_LD_RHL;
        end else begin
            if (op == OPC_ST_HLN)       cls = C_X_STN;
            else if (is_mem_ld)         cls = C_X_LDR;
        end
    end

endmodule

// File: rtl/ldseq_regfile.sv
// Byte register file: one write port and all entries readable in parallel.
// Assumes a single write per clock; reset clears every entry.
module ldseq_regfile #(
    parameter int NREG = 7,
    parameter int DW   = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [RW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  q
);

    // Store the write data into the addressed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (waddr == RW'(i)) q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/ldseq_top.sv
// Machine-cycle sequencer for the byte-load instruction subset.
// Walks fetch, read, extended and write cycles with a state counter.
// Samples read data on the final state of each read or fetch cycle.
// Assumes: AW is 16 (two bytes form an address); memory answers combinationally;
// index bases are fixed by IX_INIT / IY_INIT since no load here writes them.
module ldseq_top
    import ldseq_pkg::*;
#(
    parameter int           AW      = 16,
    parameter logic [AW-1:0] PC_INIT = '0,
    parameter logic [AW-1:0] IX_INIT = '0,
    parameter logic [AW-1:0] IY_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_rdata,
    output logic [BW-1:0] bus_wdata,
    output logic          bus_m1,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [2:0]    t_state
);

    localparam int NREG = 7;
    localparam int RW   = $clog2(NREG);
    localparam int HW   = AW / 2;

    phase_e          phase_q;
    cls_e            cls_q, cls_in;
    logic [2:0]      tcnt_q, dst_q;
    logic [AW-1:0]   pc_q, ea, idx_base;
    logic            pfx_q, iy_q, cyc_last;
    logic [HW-1:0]   lo_q, hi_q;
    logic [BW-1:0]   dsp_q, imm_q;
    logic            rf_we;
    logic [RW-1:0]   rf_waddr;
    logic [NREG-1:0][BW-1:0] rf_q;

    ldseq_decode u_dec (
        .op  (bus_rdata),
        .pfx (pfx_q),
        .cls (cls_in)
    );

    ldseq_regfile #(.NREG(NREG), .DW(BW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (bus_rdata),
        .q     (rf_q)
    );

    assign cyc_last = (tcnt_q == phase_len(phase_q));
    assign idx_base = iy_q ? IY_INIT : IX_INIT;

    // Register write happens at the end of the operand read cycle
    always_comb begin
        rf_we    = (phase_q == P_RD) && cyc_last;
        rf_waddr = ((cls_q == C_LD_RHL) || (cls_q == C_X_LDR)) ? slot_of(dst_q) : SLOT_A;
    end

    // Effective address of the memory operand for each instruction class
    always_comb begin
        case (cls_q)
            C_ST_BC, C_LD_BC:   ea = {rf_q[SLOT_B], rf_q[SLOT_C]};
            C_ST_DE, C_LD_DE:   ea = {rf_q[SLOT_D], rf_q[SLOT_E]};
            C_ST_NN, C_LD_NN:   ea = {hi_q, lo_q};
            C_ST_HLN, C_LD_RHL: ea = {rf_q[SLOT_H], rf_q[SLOT_L]};
            C_X_STN, C_X_LDR:   ea = idx_base + {{(AW-BW){dsp_q[BW-1]}}, dsp_q};
            default:            ea = pc_q;
        endcase
    end

    // Bus address, data and per-state strobes
    always_comb begin
        bus_addr  = ((phase_q == P_RD) || (phase_q == P_WR)) ? ea : pc_q;
        bus_wdata = ((cls_q == C_ST_HLN) || (cls_q == C_X_STN)) ? imm_q : rf_q[SLOT_A];
        bus_m1    = (phase_q == P_OP);
        bus_rd    = (phase_q != P_CALC) && (phase_q != P_WR);
        bus_wr    = (phase_q == P_WR) && cyc_last;
        t_state   = tcnt_q;
    end

    // State counter, phase sequencing and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= P_OP;
            tcnt_q  <= 3'd1;
            pc_q    <= PC_INIT;
            pfx_q   <= 1'b0;
            iy_q    <= 1'b0;
            cls_q   <= C_NOP;
            dst_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            dsp_q   <= '0;
            imm_q   <= '0;
        end else if (!cyc_last) begin
            tcnt_q <= tcnt_q + 3'd1;
        end else begin
            tcnt_q <= 3'd1;
            case (phase_q)
                P_OP: begin
                    cls_q <= cls_in;
                    dst_q <= bus_rdata[5:3];
                    pc_q  <= pc_q + AW'(1);
                    case (cls_in)
                        C_PFX: begin
                            pfx_q   <= 1'b1;
                            iy_q    <= bus_rdata[5];
                            phase_q <= P_OP;
                        end
                        C_X_STN, C_X_LDR:           phase_q <= P_DISP;
                        C_ST_BC, C_ST_DE:           phase_q <= P_WR;
                        C_ST_NN, C_LD_NN:           phase_q <= P_ALO;
                        C_ST_HLN:                   phase_q <= P_IMM;
                        C_LD_BC, C_LD_DE, C_LD_RHL: phase_q <= P_RD;
                        default: begin
                            pfx_q   <= 1'b0;
                            phase_q <= P_OP;
                        end
                    endcase
                end
                P_DISP: begin
                    dsp_q   <= bus_rdata;
                    pc_q    <= pc_q + AW'(1);
                    phase_q <= (cls_q == C_X_STN) ? P_XIMM : P_CALC;
                end
                P_XIMM: begin
                    imm_q   <= bus_rdata;
                    pc_q    <= pc_q + AW'(1);
                    phase_q <= P_WR;
                end
                P_CALC: phase_q <= P_RD;
                P_ALO: begin
                    lo_q    <= bus_rdata;
                    pc_q    <= pc_q + AW'(1);
                    phase_q <= P_AHI;
                end
                P_AHI: begin
                    hi_q    <= bus_rdata;
                    pc_q    <= pc_q + AW'(1);
                    phase_q <= (cls_q == C_ST_NN) ? P_WR : P_RD;
                end
                P_IMM: begin
                    imm_q   <= bus_rdata;
                    pc_q    <= pc_q + AW'(1);
                    phase_q <= P_WR;
                end
                default: begin
                    pfx_q   <= 1'b0;
                    phase_q <= P_OP;
                end
            endcase
        end
    end

    // R2: a fetch cycle ends after its fourth state
    a_r2_fetch_len: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_m1 && t_state == 3'd4) |=> (t_state == 3'd1));

    // R2: the write strobe stands alone in the third state
    a_r2_wr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (!bus_rd && !bus_m1 && t_state == 3'd3));

    // R2: address and data stay put across the write cycle
    a_r2_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($stable(bus_addr) && $stable(bus_wdata)));

    // R2: every fetch is also a read
    a_r2_m1_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_m1 |-> bus_rd);

    // R6: registers change only at the close of an operand read
    a_r6_rf_we: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (bus_rd && !bus_m1 && t_state == 3'd3));

    // R8: the five-state cycle without a read strobe drives nothing
    a_r8_calc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (t_state == 3'd5 && !bus_rd) |-> (!bus_wr && !bus_m1));

    // R11: the program counter moves by exactly one, with wrap
    a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + AW'(1)));

endmodule

// File: tb/tb_ldseq_top.sv
// Bench: directed opening plus seeded random instruction stream, checked
// against an instruction-level reference model run ahead of the design.
module tb_ldseq_top;

    localparam logic [15:0] PC0 = 16'hFFF4;
    localparam logic [15:0] IXB = 16'h0040;
    localparam logic [15:0] IYB = 16'hFFC0;
    localparam int NI    = 500;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata = 8'h00;
    logic [7:0]  bus_wdata;
    logic        bus_m1, bus_rd, bus_wr;
    logic [2:0]  t_state;

    ldseq_top #(.AW(16), .PC_INIT(PC0), .IX_INIT(IXB), .IY_INIT(IYB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .bus_m1(bus_m1), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .t_state(t_state)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory contents not yet written: a fixed scramble of the address
    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    logic [7:0] imem [logic [15:0]];
    logic [7:0] dmem [logic [15:0]];

    function automatic logic [7:0] im_rd(input logic [15:0] a);
        return imem.exists(a) ? imem[a] : fill(a);
    endfunction
    function automatic logic [7:0] dm_rd(input logic [15:0] a);
        return dmem.exists(a) ? dmem[a] : fill(a);
    endfunction

    // Program builder
    logic [15:0] gp = PC0;
    task automatic emit(input logic [7:0] b);
        imem[gp] = b;
        dmem[gp] = b;
        gp = gp + 16'd1;
    endtask

    // Reference model state and expected traces
    logic [7:0]  xr [8];
    logic [15:0] xpc;
    logic [15:0] start_q [$];
    int          st_exp [$];
    int          mc_exp [$];
    string       tg_q [$];
    logic [15:0] wa_q [$];
    logic [7:0]  wd_q [$];
    string       wt_q [$];

    task automatic mwr(input logic [15:0] a, input logic [7:0] d, input string t);
        imem[a] = d;
        wa_q.push_back(a);
        wd_q.push_back(d);
        wt_q.push_back(t);
    endtask

    task automatic rec(input int s, input int m, input string t);
        st_exp.push_back(s);
        mc_exp.push_back(m);
        tg_q.push_back(t);
    endtask

    function automatic bit is_mld(input logic [7:0] o);
        return (o[7:6] == 2'b01) && (o[2:0] == 3'b110) && (o[5:3] != 3'b110);
    endfunction

    // Execute one instruction on the reference model
    task automatic iss_step();
        logic [7:0] op, nb, d, n, lo, hi;
        logic [15:0] s0, ea;
        s0 = xpc;
        start_q.push_back(xpc);
        op = im_rd(xpc); xpc = xpc + 16'd1;
        if (op[7:6] == 2'b11 && op[4:0] == 5'b11101) begin
            nb = im_rd(xpc); xpc = xpc + 16'd1;
            if (nb == 8'h36) begin
                d = im_rd(xpc); xpc = xpc + 16'd1;
                n = im_rd(xpc); xpc = xpc + 16'd1;
                ea = (op[5] ? IYB : IXB) + {{8{d[7]}}, d};
                mwr(ea, n, "R9");
                rec(19, 5, "R9");
            end else if (is_mld(nb)) begin
                d = im_rd(xpc); xpc = xpc + 16'd1;
                ea = (op[5] ? IYB : IXB) + {{8{d[7]}}, d};
                xr[nb[5:3]] = im_rd(ea);
                rec(19, 5, "R8");
            end else begin
                rec(8, 2, "R10");
            end
        end else begin
            case (op)
                8'h02: begin mwr({xr[0], xr[1]}, xr[7], "R3"); rec(7, 2, "R3"); end
                8'h12: begin mwr({xr[2], xr[3]}, xr[7], "R3"); rec(7, 2, "R3"); end
                8'h32: begin
                    lo = im_rd(xpc); xpc = xpc + 16'd1;
                    hi = im_rd(xpc); xpc = xpc + 16'd1;
                    mwr({hi, lo}, xr[7], "R4"); rec(13, 4, "R4");
                end
                8'h36: begin
                    n = im_rd(xpc); xpc = xpc + 16'd1;
                    mwr({xr[4], xr[5]}, n, "R5"); rec(10, 3, "R5");
                end
                8'h0A: begin xr[7] = im_rd({xr[0], xr[1]}); rec(7, 2, "R7"); end
                8'h1A: begin xr[7] = im_rd({xr[2], xr[3]}); rec(7, 2, "R7"); end
                8'h3A: begin
                    lo = im_rd(xpc); xpc = xpc + 16'd1;
                    hi = im_rd(xpc); xpc = xpc + 16'd1;
                    xr[7] = im_rd({hi, lo}); rec(13, 4, "R7");
                end
                default: begin
                    if (is_mld(op)) begin
                        xr[op[5:3]] = im_rd({xr[4], xr[5]});
                        rec(7, 2, "R6");
                    end else begin
                        rec(4, 1, "R10");
                    end
                end
            endcase
        end
        if (xpc < s0) tg_q[tg_q.size() - 1] = "R11";
    endtask

    // Random instruction of a chosen form
    task automatic emit_random();
        int k;
        logic [7:0] pf;
        k  = $urandom_range(0, 11);
        pf = $urandom_range(0, 1) ? 8'hFD : 8'hDD;
        case (k)
            0: emit(8'h02);
            1: emit(8'h12);
            2: begin emit(8'h32); emit(8'($urandom)); emit(8'($urandom)); end
            3: begin emit(8'h36); emit(8'($urandom)); end
            4: emit(8'h0A);
            5: emit(8'h1A);
            6: begin emit(8'h3A); emit(8'($urandom)); emit(8'($urandom)); end
            7: emit({2'b01, 3'($urandom_range(0, 5)), 3'b110});
            8: begin emit(pf); emit(8'h36); emit(8'($urandom)); emit(8'($urandom)); end
            9: begin emit(pf); emit({2'b01, ($urandom_range(0, 1) ? 3'b111 : 3'($urandom_range(0, 5))), 3'b110}); emit(8'($urandom)); end
            10: emit(8'($urandom));
            default: begin emit(pf); emit(8'($urandom)); end
        endcase
    endtask

    // Monitor state
    int  cyc = 0;
    int  k_i = 0;
    int  t0 = 0;
    int  mc = 0;
    bit  done = 1'b0;
    logic [15:0] wa;
    logic [7:0]  wd;
    string       wt;

    // Sample outputs mid-cycle, model memory, and check traces
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            if (cyc == 1) begin
                chk(t_state == 3'd1 && bus_m1 && bus_rd && !bus_wr, "R1", "reset strobes",
                    {t_state, bus_m1, bus_rd, bus_wr}, {3'd1, 3'b110});
                chk(bus_addr == PC0, "R1", "reset fetch address", bus_addr, PC0);
            end
            if (bus_wr) begin
                chk(t_state == 3'd3 && !bus_rd && !bus_m1, "R2", "write strobe state",
                    {t_state, bus_rd, bus_m1}, {3'd3, 2'b00});
                if (wa_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected write", bus_addr, 0);
                end else begin
                    wa = wa_q.pop_front(); wd = wd_q.pop_front(); wt = wt_q.pop_front();
                    chk(bus_addr == wa, wt, "write address", bus_addr, wa);
                    chk(bus_wdata == wd, wt, "write data", bus_wdata, wd);
                end
                dmem[bus_addr] = bus_wdata;
            end
            if (t_state == 3'd1) begin
                if (bus_m1 && k_i < start_q.size() && bus_addr == start_q[k_i]) begin
                    if (k_i > 0) begin
                        chk(cyc - t0 == st_exp[k_i-1], tg_q[k_i-1], "state count",
                            cyc - t0, st_exp[k_i-1]);
                        chk(mc == mc_exp[k_i-1], tg_q[k_i-1], "machine cycle count",
                            mc, mc_exp[k_i-1]);
                    end
                    t0 = cyc;
                    mc = 1;
                    k_i++;
                    if (k_i == NI + 1) done = 1'b1;
                end else begin
                    mc++;
                    if (bus_m1) chk(bus_rd, "R2", "fetch read strobe", bus_rd, 1);
                end
            end
            bus_rdata = dm_rd(bus_addr);
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) xr[i] = 8'h00;
        // Directed opening: reset registers, index wrap, no-op forms
        emit(8'h02);                             // store zero A at 0x0000
        emit(8'hDD); emit(8'h7E); emit(8'h80);   // A <- (IX-128), wraps below 0
        emit(8'h32); emit(8'h10); emit(8'h20);   // A -> 0x2010
        emit(8'hFD); emit(8'h46); emit(8'h7F);   // B <- (IY+127), wraps above FFFF
        emit(8'hFD); emit(8'h36); emit(8'h45); emit(8'hC3);
        emit(8'h76);
        emit(8'hDD); emit(8'hFD);
        emit(8'hDD); emit(8'h0A);
        emit(8'h4E); emit(8'h02);
        emit(8'h66); emit(8'h6E); emit(8'h36); emit(8'h99);
        emit(8'h1A); emit(8'h12); emit(8'h3A); emit(8'h00); emit(8'h20);
        emit(8'hDD); emit(8'h36); emit(8'hFF); emit(8'h5A);
        emit(8'hDD); emit(8'h56); emit(8'hFF); emit(8'h12);
        while (gp > 16'h0800 || gp < 16'h0400) emit_random();
        xpc = PC0;
        for (int i = 0; i < NI; i++) iss_step();
        start_q.push_back(xpc);
        tg_q[0] = "R1";
        wt_q[0] = "R1";

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        while (!done && cyc < LIMIT) @(posedge clk);
        if (!done) chk(1'b0, "R2", "watchdog expired at instruction", k_i, NI);
        chk(wa_q.size() == 0, "R3", "writes left unperformed", wa_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule